// File: doc/BRIEF.md
# Address-Operand Hazard Interlock

This block guards the effective-address (EA) stage of a six-stage in-order pipeline: decode, operand fetch, EA calculation, memory access, main ALU, write-back. Two ALUs produce register results. A fast address adder in the EA stage handles address add, address subtract and load-address operations. Every other operation completes in the main ALU, two stages further down. Each cycle the block looks at the instruction in the EA stage, which supplies its base and index register numbers, its destination register, and which ALU computes that destination. It compares these against the three older instructions in flight.

If an address operand comes from a main-ALU result that has not yet reached write-back, the block asserts a stall. The stall holds decode, operand fetch and the EA stage, and places a bubble into the memory stage. In every other case it tells the EA datapath where each operand comes from: the register file, or the result held in one of the three later stages. A flush input drops all tracked instructions at once.

Top module: `ea_hazard_unit`

## Requirements
- R1: While reset is held, and in the first cycle after it, `stall_o` is 0 and every `fwd_sel_o` field is 0. No earlier instruction is tracked.
- R2: A register number is 4 bits. Bit 3 = 1 selects an address register and bit 3 = 0 a data register, with bits 2:0 the index. Hazards are tracked on all 16, so data register 3 (4'b0011) and address register 3 (4'b1011) never match.
- R3: A result from the EA-stage adder (`dst_late_i` = 0) never causes a stall. A consumer one, two or three instructions behind gets forward codes 1, 2 or 3.
- R4: A main-ALU result (`dst_late_i` = 1) used as base or index by the very next instruction stalls that instruction for exactly 2 cycles. It then proceeds with forward code 3.
- R5: A main-ALU result used by the instruction two behind the producer stalls it for exactly 1 cycle.
- R6: A main-ALU result used by the instruction three behind the producer causes no stall, and that consumer gets forward code 3.
- R7: When several tracked instructions write the consumer's register, only the youngest of them decides the stall and the forward code.
- R8: A producer with `dst_valid_i` = 0 is never matched. A source whose valid bit is 0, or any source while `ea_valid_i` = 0, never stalls and gets forward code 0.
- R9: Each stall cycle inserts a bubble ahead of the held instruction. The held instruction enters the memory stage exactly once, in the cycle it is accepted.
- R10: While `flush_i` is 1, `stall_o` is 0 and all forward codes are 0. After that edge no earlier instruction is tracked, including the one in the EA stage during the flush.
- R11: `fwd_sel_o[1:0]` is the base operand and `fwd_sel_o[3:2]` is the index operand. The codes are 0 = register file, 1 = memory stage, 2 = main-ALU stage, 3 = write-back stage. Both fields are 0 during a stall.
- R12: Base and index are checked independently, and a hazard on either one alone stalls the instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Drop all in-flight tracking |
| ea_valid_i | input | 1 | A valid instruction is in the EA stage |
| src_valid_i | input | 2 | Per-source valid: bit 0 is base, bit 1 is index |
| src_reg_i | input | 8 | Source register numbers: [3:0] is base, [7:4] is index |
| dst_valid_i | input | 1 | The EA-stage instruction writes a register |
| dst_reg_i | input | 4 | Destination register number |
| dst_late_i | input | 1 | 1 means the main ALU produces the destination, 0 means the EA adder does |
| stall_o | output | 1 | Hold the front stages and insert a bubble |
| fwd_sel_o | output | 4 | Forward codes, 2 bits per source |

## Verification
The assertions assume that the front end keeps the EA-stage inputs unchanged while `stall_o` is high, and that a flush lasts at least one cycle. They also assume that a held instruction sees no new producers in front of it, because stalls insert only bubbles.

The stimulus re-drives the same instruction until no stall is expected, and it applies flush only on whole cycles. The bench therefore never steps outside these assumptions. Directed sequences place producers at distances one to four with both ALU kinds. The bench then runs a long random phase over a small register set so that duplicate writers and both-operand hazards occur often.

// File: rtl/ea_hz_pkg.sv
package ea_hz_pkg;
  localparam int REG_W     = 4;
  localparam int NUM_SLOTS = 3;  // memory, main-ALU, write-back stages
  localparam int SEL_W     = 2;

  typedef struct packed {
    logic             valid;
    logic             late;
    logic [REG_W-1:0] dst;
  } slot_t;

  typedef enum logic [SEL_W-1:0] {
    FWD_RF = 2'd0,
    FWD_S4 = 2'd1,
    FWD_S5 = 2'd2,
    FWD_WB = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/ea_hz_tracker.sv
module ea_hz_tracker
  import ea_hz_pkg::*;
(
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    flush_i,
  input  slot_t                   new_i,
  output slot_t [NUM_SLOTS-1:0]   slots_o
);
  slot_t [NUM_SLOTS-1:0] slots_q;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    slot_t nxt;
    if (i == 0) begin : g_head
      assign nxt = new_i;
    end else begin : g_tail
      assign nxt = slots_q[i-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      slots_q[i] <= '0;
      else if (flush_i) slots_q[i] <= '0;
      else              slots_q[i] <= nxt;
    end
  end

  assign slots_o = slots_q;

  p_flush_empties_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (slots_q[0].valid == 1'b0 && slots_q[1].valid == 1'b0 && slots_q[2].valid == 1'b0));
endmodule

// File: rtl/ea_hz_match.sv
module ea_hz_match
  import ea_hz_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  slot_t [NUM_SLOTS-1:0]  slots_i,
  input  logic                   src_valid_i,
  input  logic [REG_W-1:0]       src_i,
  output logic                   hazard_o,
  output fwd_sel_e               sel_o
);
  // oldest first, so the youngest match overrides
  always_comb begin
    hazard_o = 1'b0;
    sel_o    = FWD_RF;
    if (src_valid_i) begin
      for (int k = NUM_SLOTS-1; k >= 0; k--) begin
        if (slots_i[k].valid && slots_i[k].dst == src_i) begin
          sel_o    = fwd_sel_e'(SEL_W'(k + 1));
          hazard_o = slots_i[k].late && (k != NUM_SLOTS-1);
        end
      end
    end
  end

  p_hazard_needs_late_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hazard_o |-> (src_valid_i && ((slots_i[0].valid && slots_i[0].late) ||
                                  (slots_i[1].valid && slots_i[1].late))));

  p_idle_source_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_valid_i |-> (!hazard_o && sel_o == FWD_RF));
endmodule

// File: rtl/ea_hazard_unit.sv
module ea_hazard_unit
  import ea_hz_pkg::*;
#(
  parameter int NUM_SRC = 2
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      flush_i,
  input  logic                      ea_valid_i,
  input  logic [NUM_SRC-1:0]        src_valid_i,
  input  logic [NUM_SRC*REG_W-1:0]  src_reg_i,
  input  logic                      dst_valid_i,
  input  logic [REG_W-1:0]          dst_reg_i,
  input  logic                      dst_late_i,
  output logic                      stall_o,
  output logic [NUM_SRC*SEL_W-1:0]  fwd_sel_o
);
  slot_t [NUM_SLOTS-1:0] slots;
  slot_t                 new_slot;
  logic  [NUM_SRC-1:0]   haz;
  fwd_sel_e              sel [NUM_SRC];

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    ea_hz_match u_match (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .slots_i     (slots),
      .src_valid_i (ea_valid_i & src_valid_i[s]),
      .src_i       (src_reg_i[s*REG_W +: REG_W]),
      .hazard_o    (haz[s]),
      .sel_o       (sel[s])
    );
  end

  assign stall_o = ea_valid_i & ~flush_i & (|haz);

  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      fwd_sel_o[s*SEL_W +: SEL_W] = (stall_o | flush_i) ? FWD_RF : sel[s];
    end
  end

  // a stalled instruction leaves a bubble behind it
  always_comb begin
    new_slot.valid = ea_valid_i & dst_valid_i & ~stall_o;
    new_slot.late  = dst_late_i;
    new_slot.dst   = dst_reg_i;
  end

  ea_hz_tracker u_track (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush_i),
    .new_i   (new_slot),
    .slots_o (slots)
  );

  p_flush_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (!stall_o && fwd_sel_o == '0));

  p_no_stall_after_flush_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !stall_o);

  p_stall_run_le2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && $past(stall_o)) |=> !stall_o);

  p_bubble_on_stall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !slots[0].valid);

  p_stall_fwd_zero_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> $countones(fwd_sel_o) == 0);
endmodule

// File: tb/ea_hazard_unit_test.sv
module ea_hazard_unit_test;
  localparam int CLK_PERIOD = 10;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic fl = 1'b0, ea_v = 1'b0, b_v = 1'b0, i_v = 1'b0, d_v = 1'b0, d_l = 1'b0;
  logic [3:0] b_r = '0, i_r = '0, d_r = '0;
  logic stall_o;
  logic [3:0] fwd_sel_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ea_hazard_unit uut (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (fl),
    .ea_valid_i  (ea_v),
    .src_valid_i ({i_v, b_v}),
    .src_reg_i   ({i_r, b_r}),
    .dst_valid_i (d_v),
    .dst_reg_i   (d_r),
    .dst_late_i  (d_l),
    .stall_o     (stall_o),
    .fwd_sel_o   (fwd_sel_o)
  );

  int n_chk = 0, n_fail = 0;
  // reference pipeline: index 0 = memory stage, 2 = write-back
  bit mv[3], ml[3];
  int md[3];
  bit exp_st;
  bit [3:0] exp_fs;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int src_sel(input bit v, input int r, output bit h);
    int sel = 0;
    h = 0;
    for (int k = 2; k >= 0; k--) begin
      if (v && mv[k] && md[k] == r) begin
        sel = k + 1;
        h = ml[k] && (k < 2);
      end
    end
    return sel;
  endfunction

  task automatic model_eval();
    bit h0, h1;
    int s0, s1;
    s0 = src_sel(ea_v && b_v, int'(b_r), h0);
    s1 = src_sel(ea_v && i_v, int'(i_r), h1);
    exp_st = ea_v && !fl && (h0 || h1);
    exp_fs = (exp_st || fl) ? 4'd0 : {2'(s1), 2'(s0)};
  endtask

  task automatic model_step();
    if (fl || !rst_ni) begin
      for (int k = 0; k < 3; k++) mv[k] = 0;
    end else begin
      for (int k = 2; k > 0; k--) begin
        mv[k] = mv[k-1]; ml[k] = ml[k-1]; md[k] = md[k-1];
      end
      mv[0] = ea_v && d_v && !exp_st;
      ml[0] = d_l;
      md[0] = int'(d_r);
    end
  endtask

  // inputs are set just after a falling edge; compare, then advance one clock
  task automatic run_cycle(input string tag);
    #1;
    model_eval();
    chk(stall_o === exp_st, tag, "stall_o", int'(stall_o), int'(exp_st));
    chk(fwd_sel_o === exp_fs, tag, "fwd_sel_o", int'(fwd_sel_o), int'(exp_fs));
    model_step();
    @(negedge clk_i);
  endtask

  task automatic issue(input string tag, input bit bv, input int br, input bit iv, input int ir,
                       input bit dv, input int dr, input bit dl, output int stalls);
    ea_v = 1; b_v = bv; b_r = 4'(br); i_v = iv; i_r = 4'(ir);
    d_v = dv; d_r = 4'(dr); d_l = dl;
    stalls = 0;
    for (int g = 0; g < 8; g++) begin
      #1;
      model_eval();
      run_cycle(tag);
      if (!exp_st) break;
      stalls++;
    end
    ea_v = 0; b_v = 0; i_v = 0; d_v = 0;
  endtask

  task automatic idle(input string tag);
    ea_v = 0; run_cycle(tag);
  endtask

  task automatic flush_cycle(input string tag);
    fl = 1; run_cycle(tag); fl = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int st;
    for (int k = 0; k < 3; k++) begin mv[k] = 0; ml[k] = 0; md[k] = 0; end
    @(negedge clk_i);
    run_cycle("R1");                 // outputs during reset
    ea_v = 1; b_v = 1; b_r = 4'd5;
    run_cycle("R1");
    rst_ni = 1;
    run_cycle("R1");                 // first cycle out of reset
    ea_v = 0; b_v = 0;

    // R3: early-adder producer, consumers at distance 1..4
    for (int d = 1; d <= 4; d++) begin
      issue("R3", 0, 0, 0, 0, 1, 4'b1010, 0, st);
      for (int g = 1; g < d; g++) issue("R3", 0, 0, 0, 0, 0, 0, 0, st);
      issue("R3", 1, 4'b1010, 0, 0, 0, 0, 0, st);
      chk(st == 0, "R3", "stall cycles", st, 0);
      repeat (3) idle("R3");
    end

    // R4: adjacent main-ALU consumer
    issue("R4", 0, 0, 0, 0, 1, 4'b1011, 1, st);
    issue("R4", 1, 4'b1011, 0, 0, 0, 0, 0, st);
    chk(st == 2, "R4", "stall cycles", st, 2);
    repeat (3) idle("R4");

    // R5: two behind
    issue("R5", 0, 0, 0, 0, 1, 4'b0001, 1, st);
    issue("R5", 0, 0, 0, 0, 0, 0, 0, st);
    issue("R5", 0, 0, 1, 4'b0001, 0, 0, 0, st);
    chk(st == 1, "R5", "stall cycles", st, 1);
    repeat (3) idle("R5");

    // R6: three behind
    issue("R6", 0, 0, 0, 0, 1, 4'b0010, 1, st);
    issue("R6", 0, 0, 0, 0, 0, 0, 0, st);
    issue("R6", 0, 0, 0, 0, 0, 0, 0, st);
    issue("R6", 1, 4'b0010, 0, 0, 0, 0, 0, st);
    chk(st == 0, "R6", "stall cycles", st, 0);
    repeat (3) idle("R6");

    // R2: data 3 vs address 3
    issue("R2", 0, 0, 0, 0, 1, 4'b0011, 1, st);
    issue("R2", 1, 4'b1011, 0, 0, 0, 0, 0, st);
    chk(st == 0, "R2", "stall cycles", st, 0);
    repeat (3) idle("R2");
    issue("R2", 0, 0, 0, 0, 1, 4'b1111, 1, st);
    issue("R2", 1, 4'b1111, 0, 0, 0, 0, 0, st);
    chk(st == 2, "R2", "address reg stall cycles", st, 2);
    repeat (3) idle("R2");

    // R7: youngest writer decides
    issue("R7", 0, 0, 0, 0, 1, 4'b1100, 1, st);
    issue("R7", 0, 0, 0, 0, 1, 4'b1100, 0, st);
    issue("R7", 1, 4'b1100, 0, 0, 0, 0, 0, st);
    chk(st == 0, "R7", "early younger stall cycles", st, 0);
    repeat (3) idle("R7");
    issue("R7", 0, 0, 0, 0, 1, 4'b1101, 0, st);
    issue("R7", 0, 0, 0, 0, 1, 4'b1101, 1, st);
    issue("R7", 1, 4'b1101, 0, 0, 0, 0, 0, st);
    chk(st == 2, "R7", "late younger stall cycles", st, 2);
    repeat (3) idle("R7");

    // R8: no destination, invalid source
    issue("R8", 0, 0, 0, 0, 0, 4'b0100, 1, st);
    issue("R8", 1, 4'b0100, 0, 0, 0, 0, 0, st);
    chk(st == 0, "R8", "no-dst stall cycles", st, 0);
    issue("R8", 0, 0, 0, 0, 1, 4'b0101, 1, st);
    issue("R8", 0, 4'b0101, 0, 4'b0101, 0, 0, 0, st);
    chk(st == 0, "R8", "invalid-src stall cycles", st, 0);
    repeat (3) idle("R8");

    // R12: index alone
    issue("R12", 0, 0, 0, 0, 1, 4'b0110, 1, st);
    issue("R12", 1, 4'b0111, 1, 4'b0110, 0, 0, 0, st);
    chk(st == 2, "R12", "index stall cycles", st, 2);
    repeat (3) idle("R12");

    // R9: stalled instruction enters the memory stage once
    issue("R9", 0, 0, 0, 0, 1, 4'b1000, 1, st);
    issue("R9", 1, 4'b1000, 0, 0, 1, 4'b1001, 0, st);
    ea_v = 1; b_v = 1; b_r = 4'b1001;
    #1;
    chk(stall_o === 1'b0 && fwd_sel_o === 4'd1, "R9", "fwd after held producer",
        int'(fwd_sel_o), 1);
    run_cycle("R9");
    ea_v = 0; b_v = 0;
    repeat (3) idle("R9");

    // R10: flush drops the producer, and quiets an active stall
    issue("R10", 0, 0, 0, 0, 1, 4'b0111, 1, st);
    flush_cycle("R10");
    issue("R10", 1, 4'b0111, 0, 0, 0, 0, 0, st);
    chk(st == 0, "R10", "stall after flush", st, 0);
    issue("R10", 0, 0, 0, 0, 1, 4'b0111, 1, st);
    ea_v = 1; b_v = 1; b_r = 4'b0111; d_v = 1; d_r = 4'b0001; d_l = 1;
    fl = 1;
    #1;
    chk(stall_o === 1'b0 && fwd_sel_o === 4'd0, "R10", "outputs during flush",
        int'(stall_o), 0);
    run_cycle("R10");
    fl = 0;
    issue("R10", 1, 4'b0001, 0, 0, 0, 0, 0, st);
    chk(st == 0, "R10", "flushed EA instruction tracked", st, 0);
    repeat (3) idle("R10");

    // R11: random mix compared every cycle
    for (int n = 0; n < 3000; n++) begin
      if ($urandom_range(0, 39) == 0) flush_cycle("R11");
      else if ($urandom_range(0, 5) == 0) idle("R11");
      else issue("R11", 1'($urandom), int'($urandom_range(0, 3)) | (int'($urandom_range(0, 1)) << 3),
                 1'($urandom), int'($urandom_range(0, 3)) | (int'($urandom_range(0, 1)) << 3),
                 1'($urandom), int'($urandom_range(0, 3)) | (int'($urandom_range(0, 1)) << 3),
                 1'($urandom), st);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule